// File: doc/BRIEF.md
# I2C Target Interface with Bus Event Reporting

This block is the receiving end of a two-wire serial bus. It responds to one 7-bit address taken from an input. It oversamples the clock and data lines with the system clock and recognises the bus framing conditions. It acknowledges its own address. In write transfers it collects bytes from the controller. In read transfers it serialises bytes that the host logic provides. The data line is driven only through an open-drain enable.

Every bus event that matters to the host produces a one-cycle interrupt pulse and a five-bit status word. The word holds start-seen, stop-seen, data-not-address, read-direction and buffer-full. It stays in place until the next event. Because opening and closing conditions are events in their own right, the host can use the closing condition to learn that a written message is complete. A refused byte at the end of a read also gets a code of its own.

Status word layout: bit 4 start-seen, bit 3 stop-seen, bit 2 data-not-address, bit 1 read-direction, bit 0 buffer-full.

Top module: `i2c_evt_slave`

## Requirements
- R1: A falling data line while the clock is high (opening condition) produces an `irq` pulse with status 5'b10000. Address reception then restarts.
- R2: A rising data line while the clock is high (closing condition) produces an `irq` pulse with status 5'b01000. The block then returns to idle.
- R3: The block pulls the data line low in the ninth clock after an address byte whose upper seven bits equal `own_addr`. For any other address it never drives the line and raises no event until the next opening or closing condition.
- R4: A matching address byte with direction bit 0 gives status 5'b10001 and places the address byte in `rx_data`.
- R5: Each data byte received in a write transfer gives status 5'b10101, appears in `rx_data` and is acknowledged by the block.
- R6: A matching address byte with direction bit 1 gives status 5'b10010. The block then shifts out `tx_data`, MSB first, starting at the falling clock edge that ends the acknowledge.
- R7: When the controller acknowledges a transmitted byte, status becomes 5'b10110. The next byte is taken from `tx_data` at the falling clock edge that ends that acknowledge.
- R8: When the controller refuses a transmitted byte, status becomes 5'b10100. The block releases the data line and stays idle until the next opening or closing condition.
- R9: A one-cycle `rx_rd` clears only status bit 0. It leaves the other status bits and `rx_data` unchanged.
- R10: An opening condition that arrives with no closing condition before it is reported as in R1, and a new address is accepted after it.
- R11: `irq` is high for exactly one cycle per event. `status` does not change between events except through R9, and reading it has no side effect.
- R12: The data line enable `sda_oe` only switches on while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull data line low when 1 |
| own_addr | input | 7 | Address this target answers to |
| tx_data | input | 8 | Byte to send in read transfers |
| rx_data | output | 8 | Last received address or data byte |
| rx_rd | input | 1 | Host read strobe for `rx_data`, clears buffer-full |
| irq | output | 1 | One-cycle event pulse |
| status | output | 5 | Event status word |

## Verification
The assertions assume that the bus clock stays low for more than the synchroniser latency plus a few cycles. They also assume that the controller never issues a framing condition while this block is pulling the data line low, and that `rx_rd` is a single-cycle strobe. The bench keeps to these assumptions. Its bus clock half period is twenty system clocks, and it changes the data line only a quarter period after the clock falls, by which time the block has released any acknowledge. The bench sweeps every 7-bit address against one fixed `own_addr`. It also runs a series of write and read transfers with arithmetically generated bytes.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  localparam int STAT_W = 5;

  localparam int ST_BIT_START = 4;
  localparam int ST_BIT_STOP  = 3;
  localparam int ST_BIT_DATA  = 2;
  localparam int ST_BIT_READ  = 1;
  localparam int ST_BIT_FULL  = 0;

  localparam logic [STAT_W-1:0] EV_OPEN    = 5'b10000;
  localparam logic [STAT_W-1:0] EV_CLOSE   = 5'b01000;
  localparam logic [STAT_W-1:0] EV_ADDR_WR = 5'b10001;
  localparam logic [STAT_W-1:0] EV_DATA_WR = 5'b10101;
  localparam logic [STAT_W-1:0] EV_ADDR_RD = 5'b10010;
  localparam logic [STAT_W-1:0] EV_DATA_RD = 5'b10110;
  localparam logic [STAT_W-1:0] EV_REFUSED = 5'b10100;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_ADDR,
    ENG_ACK_SET,
    ENG_ACK_HOLD,
    ENG_RX,
    ENG_TX,
    ENG_CACK_REL,
    ENG_CACK
  } eng_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);

  logic [LANES-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '1;
          else        pipe[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '1;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic open_p,
  output logic close_p,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_comb begin
    open_p   = scl_s & scl_d & sda_d & ~sda_s;
    close_p  = scl_s & scl_d & ~sda_d & sda_s;
    scl_rise = scl_s & ~scl_d;
    scl_fall = ~scl_s & scl_d;
  end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_evt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_p,
  input  logic              close_p,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ev_valid,
  output logic [STAT_W-1:0] ev_code
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] rsr_q, rsr_n;
  logic [BYTE_W-1:0] tsr_q, tsr_n;
  logic [BYTE_W-1:0] rxd_q, rxd_n;
  logic              oe_q, oe_n;
  logic              rd_q, rd_n;
  logic              upd_en;

  assign upd_en = open_p | close_p | scl_rise | scl_fall;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    rsr_n    = rsr_q;
    tsr_n    = tsr_q;
    rxd_n    = rxd_q;
    oe_n     = oe_q;
    rd_n     = rd_q;
    ev_valid = 1'b0;
    ev_code  = '0;
    if (open_p) begin
      state_n  = ENG_ADDR;
      cnt_n    = '0;
      oe_n     = 1'b0;
      ev_valid = 1'b1;
      ev_code  = EV_OPEN;
    end else if (close_p) begin
      state_n  = ENG_IDLE;
      oe_n     = 1'b0;
      ev_valid = 1'b1;
      ev_code  = EV_CLOSE;
    end else begin
      case (state_q)
        ENG_ADDR: begin
          if (scl_rise) begin
            rsr_n = {rsr_q[BYTE_W-2:0], sda_s};
            if (cnt_q == LAST_BIT) begin
              cnt_n = '0;
              if (rsr_n[BYTE_W-1:1] == own_addr) begin
                rd_n     = rsr_n[0];
                state_n  = ENG_ACK_SET;
                ev_valid = 1'b1;
                ev_code  = rsr_n[0] ? EV_ADDR_RD : EV_ADDR_WR;
                if (!rsr_n[0]) rxd_n = rsr_n;
              end else begin
                state_n = ENG_IDLE;
              end
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ENG_ACK_SET: begin
          if (scl_fall) begin
            oe_n    = 1'b1;
            state_n = ENG_ACK_HOLD;
          end
        end
        ENG_ACK_HOLD: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rd_q) begin
              tsr_n   = tx_data;
              oe_n    = ~tx_data[BYTE_W-1];
              state_n = ENG_TX;
            end else begin
              oe_n    = 1'b0;
              state_n = ENG_RX;
            end
          end
        end
        ENG_RX: begin
          if (scl_rise) begin
            rsr_n = {rsr_q[BYTE_W-2:0], sda_s};
            if (cnt_q == LAST_BIT) begin
              cnt_n    = '0;
              rxd_n    = rsr_n;
              state_n  = ENG_ACK_SET;
              ev_valid = 1'b1;
              ev_code  = EV_DATA_WR;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
        end
        ENG_TX: begin
          if (scl_rise) begin
            if (cnt_q == LAST_BIT) begin
              cnt_n   = '0;
              state_n = ENG_CACK_REL;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end else if (scl_fall) begin
            tsr_n = {tsr_q[BYTE_W-2:0], 1'b0};
            oe_n  = ~tsr_q[BYTE_W-2];
          end
        end
        ENG_CACK_REL: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            state_n = ENG_CACK;
          end
        end
        ENG_CACK: begin
          if (scl_rise) begin
            ev_valid = 1'b1;
            if (sda_s) begin
              ev_code = EV_REFUSED;
              state_n = ENG_IDLE;
            end else begin
              ev_code = EV_DATA_RD;
              state_n = ENG_ACK_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      rsr_q   <= '0;
      tsr_q   <= '0;
      rxd_q   <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      rsr_q   <= rsr_n;
      tsr_q   <= tsr_n;
      rxd_q   <= rxd_n;
      oe_q    <= oe_n;
      rd_q    <= rd_n;
    end
  end

  assign sda_oe  = oe_q;
  assign rx_data = rxd_q;

endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [STAT_W-1:0] ev_code,
  input  logic              rx_rd,
  output logic [STAT_W-1:0] status,
  output logic              irq
);

  logic [STAT_W-1:0] stat_q, stat_n;
  logic              irq_q;
  logic              stat_en;

  assign stat_en = ev_valid | rx_rd;

  always_comb begin
    stat_n = stat_q;
    if (ev_valid) begin
      stat_n = ev_code;
    end else if (rx_rd) begin
      stat_n[ST_BIT_FULL] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= ev_valid;
      if (stat_en) stat_q <= stat_n;
    end
  end

  assign status = stat_q;
  assign irq    = irq_q;

endmodule

// File: rtl/i2c_evt_slave.sv
module i2c_evt_slave
  import i2c_evt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              rx_rd,
  output logic              irq,
  output logic [STAT_W-1:0] status
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [1:0]        lines_s;
  logic              open_p, close_p, scl_rise, scl_fall;
  logic              ev_valid;
  logic [STAT_W-1:0] ev_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2c_line_sync #(.LANES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({scl_i, sda_i}),
    .dout (lines_s)
  );

  i2c_cond_det u_det (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_s   (lines_s[1]),
    .sda_s   (lines_s[0]),
    .open_p  (open_p),
    .close_p (close_p),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  i2c_byte_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .open_p  (open_p),
    .close_p (close_p),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .sda_s   (lines_s[0]),
    .own_addr(own_addr),
    .tx_data (tx_data),
    .sda_oe  (sda_oe),
    .rx_data (rx_data),
    .ev_valid(ev_valid),
    .ev_code (ev_code)
  );

  i2c_evt_status u_stat (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ev_valid(ev_valid),
    .ev_code (ev_code),
    .rx_rd   (rx_rd),
    .status  (status),
    .irq     (irq)
  );

endmodule

// File: rtl/i2c_evt_slave_chk.sv
module i2c_evt_slave_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              rx_rd,
  input logic              irq,
  input logic [4:0]        status,
  input logic [BYTE_W-1:0] rx_data
);

  // R11: event pulse lasts one cycle
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R11: status only moves on an event or a host read
  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !$past(rx_rd)) |-> $stable(status));

  // R9: host read clears only buffer-full
  p_full_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_rd) && !irq) |-> (!status[0] && status[4:1] == $past(status[4:1])
                                && $stable(rx_data)));

  // R1: every event carries exactly one of start-seen / stop-seen
  p_event_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[4] ^ status[3]));

  // R2: closing condition reports no other flags
  p_close_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && status[3]) |-> (status[2:0] == 3'b000));

  // R8: refused byte leaves the data line released
  p_refused_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && status == 5'b10100) |-> !sda_oe);

  // R12: drive only switches on while the clock line is low
  p_drive_low_clk_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

endmodule

bind i2c_evt_slave i2c_evt_slave_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_i  (scl_i),
  .sda_oe (sda_oe),
  .rx_rd  (rx_rd),
  .irq    (irq),
  .status (status),
  .rx_data(rx_data)
);

// File: tb/i2c_evt_slave_bench.sv
`timescale 1ns/1ps
module i2c_evt_slave_bench;

  localparam int H = 20;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_bus;
  logic       sda_oe;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic       rx_rd = 1'b0;
  logic       irq;
  logic [4:0] status;

  int   checks = 0;
  int   fails = 0;
  int   nlog = 0;
  logic [4:0] evlog [1024];
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_evt_slave u_i2c_evt_slave (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (m_scl),
    .sda_i   (sda_bus),
    .sda_oe  (sda_oe),
    .own_addr(OWN),
    .tx_data (tx_data),
    .rx_data (rx_data),
    .rx_rd   (rx_rd),
    .irq     (irq),
    .status  (status)
  );

  always @(negedge clk) begin
    if (irq) begin
      evlog[nlog % 1024] = status;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int last_ev(input int back);
    return int'(evlog[(nlog - 1 - back) % 1024]);
  endfunction

  task automatic bus_open();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_close();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(H);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(H/2);
    b = sda_bus; tick(H/2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic get_byte(input logic refuse, input logic [7:0] nxt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    m_sda = refuse; tick(Q);
    m_scl = 1'b1; tick(H);
    tx_data = nxt;
    m_scl = 1'b0; tick(Q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rb;
    int         base;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    chk("reset status", int'(status), 0);
    chk("reset irq", int'(irq), 0);
    chk("reset sda_oe R12", int'(sda_oe), 0);

    // R1 R2 R3 R4: sweep every address in a write transfer
    for (int a = 0; a < 128; a++) begin
      base = nlog;
      bus_open();
      chk("R1 open code", last_ev(0), 5'b10000);
      put_byte({a[6:0], 1'b0}, ack);
      chk("R3 ack on match only", int'(ack), int'(a[6:0] == OWN));
      if (a[6:0] == OWN) begin
        chk("R4 addr write code", last_ev(0), 5'b10001);
        chk("R4 addr byte in rx_data", int'(rx_data), int'({OWN, 1'b0}));
      end
      bus_close();
      chk("R2 close code", last_ev(0), 5'b01000);
      chk("R3 event count", nlog - base, (a[6:0] == OWN) ? 3 : 2);
    end

    // R3: mismatched read address also ignored
    base = nlog;
    bus_open();
    put_byte({OWN ^ 7'h01, 1'b1}, ack);
    chk("R3 no ack read mismatch", int'(ack), 0);
    chk("R3 no event after mismatch", nlog - base, 1);
    bus_close();

    // R5 R9: write transfer with generated data
    bus_open();
    put_byte({OWN, 1'b0}, ack);
    for (int k = 0; k < 32; k++) begin
      logic [7:0] d;
      d = 8'((k * 37 + 11) % 256);
      put_byte(d, ack);
      chk("R5 data ack", int'(ack), 1);
      chk("R5 data write code", last_ev(0), 5'b10101);
      chk("R5 rx_data", int'(rx_data), int'(d));
      if (k % 8 == 0) begin
        rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(2);
        chk("R9 full cleared", int'(status), 5'b10100);
        chk("R9 rx_data kept", int'(rx_data), int'(d));
      end
    end
    bus_close();
    chk("R2 close after write", int'(status), 5'b01000);

    // R11: status holds with no events
    base = nlog;
    tick(100);
    chk("R11 status held", int'(status), 5'b01000);
    chk("R11 no spurious irq", nlog - base, 0);

    // R6 R7 R8: read transfers with several patterns
    for (int p = 0; p < 4; p++) begin
      logic [7:0] t0, t1, t2;
      t0 = 8'(8'h80 >> p) | 8'(p);
      t1 = ~t0;
      t2 = 8'((p * 53 + 7) % 256);
      tx_data = t0;
      bus_open();
      put_byte({OWN, 1'b1}, ack);
      chk("R3 ack read addr", int'(ack), 1);
      chk("R6 addr read code", last_ev(0), 5'b10010);
      get_byte(1'b0, t1, rb);
      chk("R6 first byte", int'(rb), int'(t0));
      chk("R7 data read code", last_ev(0), 5'b10110);
      get_byte(1'b0, t2, rb);
      chk("R7 second byte", int'(rb), int'(t1));
      get_byte(1'b1, 8'h00, rb);
      chk("R7 third byte", int'(rb), int'(t2));
      chk("R8 refused code", last_ev(0), 5'b10100);
      chk("R8 line released", int'(sda_oe), 0);
      base = nlog;
      tick(40);
      chk("R8 idle after refuse", nlog - base, 0);
      bus_close();
      chk("R2 close after read", last_ev(0), 5'b01000);
    end

    // R10: repeated opening condition turns a write into a read
    tx_data = 8'hC6;
    bus_open();
    put_byte({OWN, 1'b0}, ack);
    put_byte(8'h42, ack);
    chk("R5 before repeat", int'(rx_data), 8'h42);
    bus_open();
    chk("R10 repeat open code", last_ev(0), 5'b10000);
    put_byte({OWN, 1'b1}, ack);
    chk("R10 ack after repeat", int'(ack), 1);
    chk("R10 read code after repeat", last_ev(0), 5'b10010);
    get_byte(1'b1, 8'h00, rb);
    chk("R10 byte after repeat", int'(rb), 8'hC6);
    bus_close();
    chk("R2 final close", int'(status), 5'b01000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule